// File: doc/BRIEF.md
# Audio capture sample packer

The packer sits between a set of capture inputs and a memory-write port. One input, chosen by a select field, streams 32-bit sample words into the block with valid/ready. From each accepted word the block cuts a bit window given by a top and a bottom bit position, and shifts it down so that it is right-justified. It then widens the window to the lane size, with either sign extension or zero fill, and places it in the next free lane of a 64-bit output word. A layout code sets the lane size. When the last lane is filled, the word goes to the memory side.

The memory side is a valid/address/data output with a ready input. A word stays presented, with stable data and address, until `mem_ready` is high in a clock cycle. While a word is waiting, the selected input sees `in_ready` low. Samples are therefore held back and never lost. The write address steps by 8 bytes for each accepted word. It goes back to the programmed start address after the word at the end address has been written. A rising edge on `force_finish` does three things: it returns the pointer to the start address, it drops the partial word and any waiting word, and it re-arms the frame alignment. A one-cycle interrupt marks every N written words.

When frame alignment is enabled, samples are thrown away until one arrives flagged as channel 0 of a frame. That sample always goes into lane 0.

Top module: `cap_packer`

## Requirements
- R1: Only the input numbered `src_sel` can transfer: `in_ready` is high on at most that one bit, and samples are taken from that input's data and first-channel flag.
- R2: The sample field is bits `cfg_msb` down to `cfg_lsb` of the accepted word, shifted down so that bit `cfg_lsb` becomes bit 0 of the lane.
- R3: With `cfg_signed` = 1, the lane bits above the field copy the field's top bit. With `cfg_signed` = 0, they are zero.
- R4: Layout code 0 packs eight 8-bit lanes, code 2 packs four 16-bit lanes and code 4 packs two 32-bit lanes. The first sample of a word goes in bits [lane-1:0] and each later sample goes in the next higher lane. One output word is produced per full set of lanes.
- R5: Layout codes 1, 3, 5, 6 and 7 are reserved. Samples are still accepted but are discarded. No output word is produced and no lane is filled.
- R6: With `cfg_sync` = 1, after reset or a flush, samples whose first flag is 0 are discarded until a sample with the flag set arrives. That sample lands in lane 0 of a fresh word. With `cfg_sync` = 0, samples fill lanes in arrival order whatever their flag.
- R7: While `mem_valid` = 1 and `mem_ready` = 0, `mem_data` and `mem_addr` hold their values and `in_ready` is low. Every sample offered during the stall is later packed, with none lost.
- R8: After each accepted write, `mem_addr` rises by 8. If the address just written equals `cfg_end_addr`, it returns to `cfg_start_addr` instead.
- R9: On the first cycle that `force_finish` is high after being low, `mem_addr` is loaded with `cfg_start_addr` and the partial and pending words are discarded. The next word starts at lane 0.
- R10: `irq` is high for one cycle after every `cfg_thresh`-th accepted write, counted since the previous pulse or flush. A threshold of 0 disables it.
- R11: After reset, `mem_valid` = 0, `irq` = 0 and `mem_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | SEL_W | Selected capture input |
| in_valid | input | N_IN | Per-input sample valid |
| in_data | input | 32*N_IN | Per-input sample words, input i in bits [32i+31:32i] |
| in_first | input | N_IN | Per-input flag marking channel 0 of a frame |
| in_ready | output | N_IN | Per-input ready, high only on the selected input |
| cfg_type | input | 3 | Lane layout code |
| cfg_msb | input | 5 | Top bit of the sample field |
| cfg_lsb | input | 5 | Bottom bit of the sample field |
| cfg_signed | input | 1 | Sign-extend the field when 1 |
| cfg_sync | input | 1 | Frame alignment on channel 0 |
| cfg_start_addr | input | AW | Initial write address |
| cfg_end_addr | input | AW | Last write address before wrapping |
| cfg_thresh | input | TH_W | Words per interrupt, 0 = off |
| force_finish | input | 1 | Rising edge resets pointer and packing |
| mem_valid | output | 1 | Output word valid |
| mem_addr | output | AW | Byte address of the output word |
| mem_data | output | 64 | Packed output word |
| mem_ready | input | 1 | Memory side accepts the word |
| irq | output | 1 | Threshold interrupt pulse |

## Verification
A sample transfers at the rising edge where it is valid and ready. A word that this sample completes shows `mem_valid` high in the very next cycle. The pointer moves and any interrupt pulse shows one cycle after the edge at which `mem_valid` and `mem_ready` were both high, and a flush takes effect one cycle after the edge that first sees `force_finish` high. The bench drives inputs on falling edges and records handshakes and interrupt pulses 1 ns after each falling edge, which is exactly the value the next rising edge uses. It then compares counts and captured words after a few settling cycles, so each result is read in the cycle in which it is due.

// File: rtl/cap_pack_pkg.sv
package cap_pack_pkg;
  localparam int SAMPLE_W  = 32;
  localparam int WORD_W    = 64;
  localparam int ADDR_STEP = WORD_W / 8;

  typedef enum logic [2:0] {
    LAYOUT_8X8  = 3'd0,
    LAYOUT_16X4 = 3'd2,
    LAYOUT_32X2 = 3'd4
  } layout_e;

  function automatic logic layout_ok(input logic [2:0] code);
    return (code == LAYOUT_8X8) || (code == LAYOUT_16X4) || (code == LAYOUT_32X2);
  endfunction
endpackage

// File: rtl/cap_field_cut.sv
module cap_field_cut
  import cap_pack_pkg::*;
(
  input  logic [SAMPLE_W-1:0] word,
  input  logic [4:0]          msb,
  input  logic [4:0]          lsb,
  input  logic                sext,
  output logic [SAMPLE_W-1:0] field
);
  logic [SAMPLE_W-1:0] shifted;
  logic [4:0]          top;
  logic                fill;

  always_comb begin
    shifted = word >> lsb;
    top     = msb - lsb;
    fill    = sext & shifted[top];
    for (int i = 0; i < SAMPLE_W; i++) begin
      field[i] = (5'(i) <= top) ? shifted[i] : fill;
    end
  end
endmodule

// File: rtl/cap_lane_fill.sv
module cap_lane_fill
  import cap_pack_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [2:0]          layout,
  input  logic                sync_en,
  input  logic                s_valid,
  input  logic                s_first,
  input  logic [SAMPLE_W-1:0] s_field,
  output logic                s_ready,
  output logic                o_valid,
  output logic [WORD_W-1:0]   o_data,
  input  logic                o_ready
);
  logic [2:0]          idx, eff_idx;
  logic [WORD_W-1:0]   acc, merged;
  logic                locked, restart, fire, take, last;
  logic [5:0]          pos;
  logic [SAMPLE_W-1:0] lane_mask;

  assign s_ready = (!o_valid || o_ready) && !flush;
  assign fire    = s_valid && s_ready;
  assign restart = sync_en && !locked && s_first;
  assign take    = fire && layout_ok(layout) && (!sync_en || locked || s_first);
  assign eff_idx = restart ? 3'd0 : idx;

  always_comb begin
    case (layout)
      LAYOUT_8X8: begin
        lane_mask = 32'h0000_00FF; pos = {eff_idx, 3'b000};       last = (eff_idx == 3'd7);
      end
      LAYOUT_16X4: begin
        lane_mask = 32'h0000_FFFF; pos = {eff_idx[1:0], 4'b0000}; last = (eff_idx[1:0] == 2'd3);
      end
      LAYOUT_32X2: begin
        lane_mask = 32'hFFFF_FFFF; pos = {eff_idx[0], 5'b00000};  last = eff_idx[0];
      end
      default: begin
        lane_mask = '0; pos = '0; last = 1'b0;
      end
    endcase
    merged = (restart ? '0 : acc) |
             ({{(WORD_W-SAMPLE_W){1'b0}}, s_field & lane_mask} << pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; acc <= '0; locked <= 1'b0; o_valid <= 1'b0; o_data <= '0;
    end else if (flush) begin
      idx <= '0; acc <= '0; locked <= 1'b0; o_valid <= 1'b0;
    end else begin
      if (o_valid && o_ready) o_valid <= 1'b0;
      if (take) begin
        if (s_first) locked <= 1'b1;
        if (last) begin
          o_data  <= merged;
          o_valid <= 1'b1;
          acc     <= '0;
          idx     <= '0;
        end else begin
          acc <= merged;
          idx <= eff_idx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr
  import cap_pack_pkg::*;
#(
  parameter int AW   = 32,
  parameter int TH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_fire,
  input  logic [AW-1:0]   start_addr,
  input  logic [AW-1:0]   end_addr,
  input  logic [TH_W-1:0] thresh,
  output logic [AW-1:0]   addr,
  output logic            irq
);
  logic [TH_W-1:0] cnt, cnt_nx;

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0; cnt <= '0; irq <= 1'b0;
    end else if (flush) begin
      addr <= start_addr; cnt <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_fire) begin
        addr <= (addr == end_addr) ? start_addr : addr + AW'(ADDR_STEP);
        if (thresh != '0 && cnt_nx == thresh) begin
          irq <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cap_packer.sv
module cap_packer
  import cap_pack_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int AW    = 32,
  parameter int TH_W  = 8,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       src_sel,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*SAMPLE_W-1:0] in_data,
  input  logic [N_IN-1:0]        in_first,
  output logic [N_IN-1:0]        in_ready,
  input  logic [2:0]             cfg_type,
  input  logic [4:0]             cfg_msb,
  input  logic [4:0]             cfg_lsb,
  input  logic                   cfg_signed,
  input  logic                   cfg_sync,
  input  logic [AW-1:0]          cfg_start_addr,
  input  logic [AW-1:0]          cfg_end_addr,
  input  logic [TH_W-1:0]        cfg_thresh,
  input  logic                   force_finish,
  output logic                   mem_valid,
  output logic [AW-1:0]          mem_addr,
  output logic [WORD_W-1:0]      mem_data,
  input  logic                   mem_ready,
  output logic                   irq
);
  logic                ff_q, flush;
  logic                sel_valid, sel_first, pk_ready;
  logic [SAMPLE_W-1:0] sel_word, field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= force_finish;
  end
  assign flush = force_finish & ~ff_q;

  always_comb begin
    sel_valid = 1'b0;
    sel_first = 1'b0;
    sel_word  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (src_sel == SEL_W'(i)) begin
        sel_valid = in_valid[i];
        sel_first = in_first[i];
        sel_word  = in_data[i*SAMPLE_W +: SAMPLE_W];
      end
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_ready
    assign in_ready[g] = (src_sel == SEL_W'(g)) && pk_ready;
  end

  cap_field_cut u_cut (
    .word  (sel_word),
    .msb   (cfg_msb),
    .lsb   (cfg_lsb),
    .sext  (cfg_signed),
    .field (field)
  );

  cap_lane_fill u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .layout  (cfg_type),
    .sync_en (cfg_sync),
    .s_valid (sel_valid),
    .s_first (sel_first),
    .s_field (field),
    .s_ready (pk_ready),
    .o_valid (mem_valid),
    .o_data  (mem_data),
    .o_ready (mem_ready)
  );

  cap_wr_ptr #(.AW(AW), .TH_W(TH_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .wr_fire    (mem_valid && mem_ready),
    .start_addr (cfg_start_addr),
    .end_addr   (cfg_end_addr),
    .thresh     (cfg_thresh),
    .addr       (mem_addr),
    .irq        (irq)
  );
endmodule

// File: rtl/cap_packer_chk.sv
module cap_packer_chk #(
  parameter int N_IN = 8,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] in_ready,
  input logic [2:0]      cfg_type,
  input logic [AW-1:0]   cfg_start_addr,
  input logic [AW-1:0]   cfg_end_addr,
  input logic            force_finish,
  input logic            mem_valid,
  input logic [AW-1:0]   mem_addr,
  input logic [63:0]     mem_data,
  input logic            mem_ready,
  input logic            irq
);
  localparam logic [AW-1:0] STEP = AW'(8);
  logic type_ok, fire;
  assign type_ok = (cfg_type == 3'd0) || (cfg_type == 3'd2) || (cfg_type == 3'd4);
  assign fire    = mem_valid && mem_ready;

  assert_single_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!type_ok && !mem_valid && !force_finish) |=> !mem_valid);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !force_finish) |=>
      (mem_valid && $stable(mem_data) && $stable(mem_addr)));

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> (in_ready == '0));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !force_finish && mem_addr != cfg_end_addr) |=> (mem_addr == $past(mem_addr) + STEP));

  assert_addr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !force_finish && mem_addr == cfg_end_addr) |=> (mem_addr == $past(cfg_start_addr)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_finish) |=> (mem_addr == $past(cfg_start_addr) && !mem_valid));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(fire && !force_finish));
endmodule

bind cap_packer cap_packer_chk #(.N_IN(N_IN), .AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .cfg_type       (cfg_type),
  .cfg_start_addr (cfg_start_addr),
  .cfg_end_addr   (cfg_end_addr),
  .force_finish   (force_finish),
  .mem_valid      (mem_valid),
  .mem_addr       (mem_addr),
  .mem_data       (mem_data),
  .mem_ready      (mem_ready),
  .irq            (irq)
);

// File: tb/tb_cap_packer.sv
module tb_cap_packer;
  localparam int N_IN = 8;
  localparam int AW   = 32;
  localparam int TH_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        src_sel = '0;
  logic [N_IN-1:0]   in_valid = '0;
  logic [N_IN*32-1:0] in_data = '0;
  logic [N_IN-1:0]   in_first = '0;
  logic [N_IN-1:0]   in_ready;
  logic [2:0]        cfg_type = 3'd2;
  logic [4:0]        cfg_msb = 5'd31, cfg_lsb = 5'd16;
  logic              cfg_signed = 1'b0, cfg_sync = 1'b0;
  logic [AW-1:0]     cfg_start_addr = 32'h2000, cfg_end_addr = 32'hFFF8;
  logic [TH_W-1:0]   cfg_thresh = '0;
  logic              force_finish = 1'b0;
  logic              mem_valid, irq;
  logic [AW-1:0]     mem_addr;
  logic [63:0]       mem_data;
  logic              mem_ready = 1'b1;

  cap_packer #(.N_IN(N_IN), .AW(AW), .TH_W(TH_W)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, n_cap = 0, n_irq = 0, sel = 0;
  bit done = 0;
  logic [63:0] cap_d [0:63];
  logic [31:0] cap_a [0:63];

  always @(negedge clk) begin
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      if (n_cap < 64) begin cap_d[n_cap] = mem_data; cap_a[n_cap] = mem_addr; end
      n_cap++;
    end
    if (rst_n && irq) n_irq++;
  end

  // type, msb, lsb, signed, input word, expected packed word
  localparam logic [109:0] VEC [0:6] = '{
    {3'd0, 5'd31, 5'd24, 1'b1, 32'hA500_0000, 64'hA5A5_A5A5_A5A5_A5A5},
    {3'd2, 5'd31, 5'd16, 1'b1, 32'h8001_1234, 64'h8001_8001_8001_8001},
    {3'd2, 5'd31, 5'd20, 1'b1, 32'h8001_0000, 64'hF800_F800_F800_F800},
    {3'd2, 5'd31, 5'd20, 1'b0, 32'h8001_0000, 64'h0800_0800_0800_0800},
    {3'd4, 5'd31, 5'd8,  1'b1, 32'hFEDC_BA98, 64'hFFFE_DCBA_FFFE_DCBA},
    {3'd4, 5'd31, 5'd0,  1'b0, 32'h1234_5678, 64'h1234_5678_1234_5678},
    {3'd0, 5'd31, 5'd28, 1'b1, 32'h9000_0000, 64'hF9F9_F9F9_F9F9_F9F9}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input logic f);
    @(negedge clk);
    src_sel = sel[2:0];
    in_valid = '0; in_first = '0;
    in_valid[sel] = 1'b1;
    in_first[sel] = f;
    in_data[sel*32 +: 32] = w;
    #1;
    while (!in_ready[sel]) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = '0; in_first = '0;
  endtask

  task automatic pulse_ff();
    @(negedge clk) force_finish = 1'b1;
    @(negedge clk) force_finish = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int base;
    logic [109:0] v;
    wait_cyc(3);
    #1;
    // R11: reset state
    check("R11 mem_valid", 64'(mem_valid), 64'd0);
    check("R11 irq", 64'(irq), 64'd0);
    check("R11 mem_addr", 64'(mem_addr), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R2/R3/R4: vector table, one input per vector
    for (int k = 0; k < 7; k++) begin
      v = VEC[k];
      sel = k;
      @(negedge clk);
      cfg_type = v[109:107]; cfg_msb = v[106:102]; cfg_lsb = v[101:97]; cfg_signed = v[96];
      pulse_ff();
      base = n_cap;
      for (int j = 0; j < (8 >> (v[109:107] >> 1)); j++) send(v[95:64], 1'b0);
      wait_cyc(3);
      check("R4 word count", 64'(n_cap - base), 64'd1);
      check("R2/R3 packed word", cap_d[base], v[63:0]);
    end

    // R1: ready only on the selected input
    sel = 5;
    @(negedge clk) src_sel = 3'd5;
    #1 check("R1 ready vector", 64'(in_ready), 64'h20);

    // R4: lane order, first sample lowest
    @(negedge clk) begin cfg_type = 3'd2; cfg_msb = 5'd31; cfg_lsb = 5'd16; cfg_signed = 1'b0; end
    pulse_ff();
    base = n_cap;
    send(32'h1111_0000, 0); send(32'h2222_0000, 0); send(32'h3333_0000, 0); send(32'h4444_0000, 0);
    wait_cyc(3);
    check("R4 lane order", cap_d[base], 64'h4444_3333_2222_1111);

    // R6: without sync, stream is shifted by two lanes
    pulse_ff();
    base = n_cap;
    send(32'hAAAA_0000, 0); send(32'hBBBB_0000, 0); send(32'h1111_0000, 1); send(32'h2222_0000, 0);
    wait_cyc(3);
    check("R6 unsynced order", cap_d[base], 64'h2222_1111_BBBB_AAAA);

    // R6: with sync, channel 0 lands in lane 0
    @(negedge clk) cfg_sync = 1'b1;
    pulse_ff();
    base = n_cap;
    send(32'hAAAA_0000, 0); send(32'hBBBB_0000, 0); send(32'h1111_0000, 1);
    send(32'h2222_0000, 0); send(32'h3333_0000, 0); send(32'h4444_0000, 0);
    wait_cyc(3);
    check("R6 synced count", 64'(n_cap - base), 64'd1);
    check("R6 synced word", cap_d[base], 64'h4444_3333_2222_1111);
    @(negedge clk) cfg_sync = 1'b0;

    // R5: reserved layout discards samples
    @(negedge clk) cfg_type = 3'd3;
    pulse_ff();
    base = n_cap;
    for (int j = 0; j < 8; j++) send(32'h5555_0000, 0);
    wait_cyc(3);
    check("R5 no output", 64'(n_cap - base), 64'd0);
    @(negedge clk) cfg_type = 3'd2;
    send(32'h0001_0000, 0); send(32'h0002_0000, 0); send(32'h0003_0000, 0); send(32'h0004_0000, 0);
    wait_cyc(3);
    check("R5 no leftover lanes", cap_d[base], 64'h0004_0003_0002_0001);

    // R8: address step and wrap
    @(negedge clk) begin cfg_type = 3'd4; cfg_lsb = 5'd0; cfg_start_addr = 32'h1000; cfg_end_addr = 32'h1010; end
    pulse_ff();
    base = n_cap;
    for (int j = 0; j < 8; j++) send(32'(j), 0);
    wait_cyc(3);
    check("R8 addr 0", 64'(cap_a[base]),   64'h1000);
    check("R8 addr 1", 64'(cap_a[base+1]), 64'h1008);
    check("R8 addr 2", 64'(cap_a[base+2]), 64'h1010);
    check("R8 addr wrap", 64'(cap_a[base+3]), 64'h1000);

    // R9: flush drops partial word and reloads pointer
    @(negedge clk) begin cfg_start_addr = 32'h3000; cfg_end_addr = 32'hFFF8; end
    send(32'hDEAD_BEEF, 0);
    pulse_ff();
    base = n_cap;
    send(32'h0000_00AA, 0); send(32'h0000_00BB, 0);
    wait_cyc(3);
    check("R9 partial dropped", cap_d[base], 64'h0000_00BB_0000_00AA);
    check("R9 addr reload", 64'(cap_a[base]), 64'h3000);

    // R7: back-pressure
    @(negedge clk) begin cfg_type = 3'd2; cfg_lsb = 5'd16; mem_ready = 1'b0; end
    pulse_ff();
    base = n_cap;
    send(32'h0011_0000, 0); send(32'h0022_0000, 0); send(32'h0033_0000, 0); send(32'h0044_0000, 0);
    fork
      begin
        send(32'h0055_0000, 0); send(32'h0066_0000, 0); send(32'h0077_0000, 0); send(32'h0088_0000, 0);
      end
      begin
        wait_cyc(2); #2;
        check("R7 valid held", 64'(mem_valid), 64'd1);
        check("R7 input stalled", 64'(in_ready[sel]), 64'd0);
        wait_cyc(4); #2;
        check("R7 data stable", mem_data, 64'h0044_0033_0022_0011);
        @(negedge clk) mem_ready = 1'b1;
      end
    join
    wait_cyc(3);
    check("R7 words after stall", 64'(n_cap - base), 64'd2);
    check("R7 second word intact", cap_d[base+1], 64'h0088_0077_0066_0055);

    // R10: threshold interrupt
    check("R10 disabled at zero", 64'(n_irq), 64'd0);
    @(negedge clk) begin cfg_type = 3'd4; cfg_lsb = 5'd0; cfg_thresh = 8'd3; end
    pulse_ff();
    base = n_irq;
    for (int j = 0; j < 12; j++) send(32'(j), 0);
    wait_cyc(4);
    check("R10 pulses for six words", 64'(n_irq - base), 64'd2);

    finish_run();
  end
endmodule